// File: doc/BRIEF.md
# Interrupt Request and In-Service Priority Tracker

This block keeps the pending-interrupt state of one interrupt controller. It holds three vector bitmaps: a request set (interrupts accepted but not yet taken), an in-service set (interrupts taken but not yet ended) and a trigger-mode set (level-triggered requests). It also holds a task priority value. From these it derives a processor priority and the single highest request vector that may be delivered now.

An upstream agent offers interrupts on the accept port. A core-side agent takes the reported vector through the acknowledge port and later signals end of interrupt. When an ended interrupt was level-triggered, the block emits a one-cycle notification that carries the vector, so that the source can re-sample its line. The block does not route interrupts to a destination and does not deliver them to a core.

Top module: `irq_prio_tracker`

## Requirements
- R1: An accept while enabled sets the request bit of its vector. `acc_new_o` is high in the same cycle exactly when that bit was clear. The highest set request vector is searched over all eight 32-bit words, with vector v at bit v mod 32 of word v/32.
- R2: An accept with `acc_level_i` high sets the vector's trigger-mode bit. An accept with it low leaves the trigger-mode bit unchanged.
- R3: `ppr_o` equals the task priority when task[7:4] >= top[7:4]. Otherwise it equals top & 0xF0. Here top is the highest in-service vector, or 0 when the in-service set is empty.
- R4: `pend_valid_o` is high only while `en_i` is high, a request bit is set, and the class (bits 7:4) of the highest request vector is strictly greater than the class of top. `pend_vec_o` is then that highest request vector.
- R5: An acknowledge sets the vector's in-service bit and clears its request bit, both on the next edge.
- R6: An end of interrupt clears only the highest set in-service bit. With no in-service bit set, it changes nothing.
- R7: An end of interrupt whose vector has its trigger-mode bit set clears that bit. It also raises `eoi_ntf_valid_o` for the single following cycle, with `eoi_ntf_vec_o` equal to the vector. An ended vector without the trigger-mode bit produces no notification.
- R8: A task priority write keeps only bits 7:0 of `tpr_wdata_i`. Reset clears all three bitmaps, the task priority and the notification.
- R9: An accept while `en_i` is low leaves the request state untouched, and `acc_new_o` stays low.
- R10: An accept and an acknowledge of the same vector in one cycle apply the acknowledge first. The request bit therefore ends up set, and the in-service bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Controller enable |
| acc_valid_i | input | 1 | Accept strobe |
| acc_vec_i | input | 8 | Vector to accept |
| acc_level_i | input | 1 | Accepted interrupt is level-triggered |
| acc_new_o | output | 1 | Accepted vector was not already requested |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_vec_i | input | 8 | Vector being acknowledged |
| eoi_i | input | 1 | End-of-interrupt strobe |
| tpr_we_i | input | 1 | Task priority write strobe |
| tpr_wdata_i | input | 32 | Task priority write data |
| pend_valid_o | output | 1 | A deliverable vector is pending |
| pend_vec_o | output | 8 | Highest deliverable request vector |
| ppr_o | output | 8 | Processor priority |
| eoi_ntf_valid_o | output | 1 | Level-triggered end-of-interrupt notification |
| eoi_ntf_vec_o | output | 8 | Vector of the notification |

## Verification
The assertions treat the acknowledge vector and the end-of-interrupt strobe as free inputs. The end-of-interrupt clearing property excludes the one cycle where an acknowledge re-sets the victim bit, because acknowledge is ordered after end of interrupt. The properties assume nothing about whether an acknowledged vector was actually pending. The stimulus still acknowledges only vectors that the bench has accepted, so every expected bitmap state stays easy to follow. Inputs change one task at a time between clock edges. Each scenario leaves a known request and in-service set for the next one.

// File: rtl/irq_prio_pkg.sv
`timescale 1ns/1ps
package irq_prio_pkg;

    // Width of the priority class carried in the top bits of a vector.
    localparam int unsigned CLASS_W = 4;

endpackage

// File: rtl/irq_highest_set.sv
`timescale 1ns/1ps
// Finds the highest set bit of a wide vector, word by word.
module irq_highest_set #(
    parameter int unsigned NUM_BITS = 256,
    parameter int unsigned WORD_W   = 32
) (
    input  logic [NUM_BITS-1:0]         bits_i,
    output logic                        found_o,
    output logic [$clog2(NUM_BITS)-1:0] idx_o
);
    localparam int unsigned IDX_W     = $clog2(NUM_BITS);
    localparam int unsigned NUM_WORDS = NUM_BITS / WORD_W;
    localparam int unsigned BIT_W     = $clog2(WORD_W);

    logic [NUM_WORDS-1:0] word_any;
    logic [BIT_W-1:0]     word_top [NUM_WORDS];

    generate
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
            logic [WORD_W-1:0] slice;
            logic [BIT_W-1:0]  top_bit;

            assign slice = bits_i[w*WORD_W +: WORD_W];

            always_comb begin
                top_bit = '0;
                for (int b = 0; b < WORD_W; b++) begin
                    if (slice[b]) top_bit = BIT_W'(b);
                end
            end

            assign word_any[w] = |slice;
            assign word_top[w] = top_bit;
        end
    endgenerate

    // Later (higher) words override earlier ones: same result as a top-down scan.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (word_any[w]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(w * WORD_W) | IDX_W'(word_top[w]);
            end
        end
    end
endmodule

// File: rtl/irq_prio_resolve.sv
`timescale 1ns/1ps
// Derives processor priority and deliverability from the scan results.
module irq_prio_resolve
    import irq_prio_pkg::*;
#(
    parameter int unsigned VEC_W = 8
) (
    input  logic             en_i,
    input  logic             req_found_i,
    input  logic [VEC_W-1:0] req_top_i,
    input  logic             svc_found_i,
    input  logic [VEC_W-1:0] svc_top_i,
    input  logic [VEC_W-1:0] tpr_i,
    output logic [VEC_W-1:0] ppr_o,
    output logic             deliver_o,
    output logic [VEC_W-1:0] deliver_vec_o
);
    localparam int unsigned LOW_W = VEC_W - CLASS_W;

    logic [VEC_W-1:0]   svc_eff;
    logic [CLASS_W-1:0] svc_cls;
    logic [CLASS_W-1:0] tpr_cls;
    logic [CLASS_W-1:0] req_cls;

    always_comb begin
        svc_eff = svc_found_i ? svc_top_i : '0;
        svc_cls = svc_eff[VEC_W-1 -: CLASS_W];
        tpr_cls = tpr_i[VEC_W-1 -: CLASS_W];
        req_cls = req_top_i[VEC_W-1 -: CLASS_W];

        if (tpr_cls >= svc_cls) ppr_o = tpr_i;
        else                    ppr_o = {svc_cls, {LOW_W{1'b0}}};

        deliver_o     = en_i && req_found_i && (req_cls > svc_cls);
        deliver_vec_o = req_top_i;
    end
endmodule

// File: rtl/irq_prio_tracker.sv
`timescale 1ns/1ps
module irq_prio_tracker #(
    parameter int unsigned NUM_VEC = 256,
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned DATA_W  = 32
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        en_i,
    input  logic                        acc_valid_i,
    input  logic [$clog2(NUM_VEC)-1:0]  acc_vec_i,
    input  logic                        acc_level_i,
    output logic                        acc_new_o,
    input  logic                        ack_valid_i,
    input  logic [$clog2(NUM_VEC)-1:0]  ack_vec_i,
    input  logic                        eoi_i,
    input  logic                        tpr_we_i,
    input  logic [DATA_W-1:0]           tpr_wdata_i,
    output logic                        pend_valid_o,
    output logic [$clog2(NUM_VEC)-1:0]  pend_vec_o,
    output logic [$clog2(NUM_VEC)-1:0]  ppr_o,
    output logic                        eoi_ntf_valid_o,
    output logic [$clog2(NUM_VEC)-1:0]  eoi_ntf_vec_o
);
    localparam int unsigned VEC_W = $clog2(NUM_VEC);

    typedef struct packed {
        logic [NUM_VEC-1:0] req;
        logic [NUM_VEC-1:0] svc;
        logic [NUM_VEC-1:0] lvl;
        logic [VEC_W-1:0]   tpr;
        logic               ntf_valid;
        logic [VEC_W-1:0]   ntf_vec;
    } state_t;

    state_t s_d, s_q;

    logic             req_found, svc_found;
    logic [VEC_W-1:0] req_top,   svc_top;
    logic             fresh_d;
    logic [VEC_W-1:0] tpr_q;
    logic [NUM_VEC-1:0] svc_q;
    logic             unused_tpr_hi;

    assign unused_tpr_hi = ^tpr_wdata_i[DATA_W-1:VEC_W];

    irq_highest_set #(.NUM_BITS(NUM_VEC), .WORD_W(WORD_W)) u_req_scan (
        .bits_i (s_q.req),
        .found_o(req_found),
        .idx_o  (req_top)
    );

    irq_highest_set #(.NUM_BITS(NUM_VEC), .WORD_W(WORD_W)) u_svc_scan (
        .bits_i (s_q.svc),
        .found_o(svc_found),
        .idx_o  (svc_top)
    );

    irq_prio_resolve #(.VEC_W(VEC_W)) u_resolve (
        .en_i         (en_i),
        .req_found_i  (req_found),
        .req_top_i    (req_top),
        .svc_found_i  (svc_found),
        .svc_top_i    (svc_top),
        .tpr_i        (s_q.tpr),
        .ppr_o        (ppr_o),
        .deliver_o    (pend_valid_o),
        .deliver_vec_o(pend_vec_o)
    );

    // Order within a cycle: end of interrupt, then acknowledge, then accept.
    always_comb begin
        s_d           = s_q;
        s_d.ntf_valid = 1'b0;
        fresh_d       = 1'b0;

        if (eoi_i && svc_found) begin
            s_d.svc[svc_top] = 1'b0;
            if (s_q.lvl[svc_top]) begin
                s_d.lvl[svc_top] = 1'b0;
                s_d.ntf_valid    = 1'b1;
                s_d.ntf_vec      = svc_top;
            end
        end

        if (ack_valid_i) begin
            s_d.svc[ack_vec_i] = 1'b1;
            s_d.req[ack_vec_i] = 1'b0;
        end

        if (acc_valid_i && en_i) begin
            fresh_d            = !s_d.req[acc_vec_i];
            s_d.req[acc_vec_i] = 1'b1;
            if (acc_level_i) s_d.lvl[acc_vec_i] = 1'b1;
        end

        if (tpr_we_i) s_d.tpr = tpr_wdata_i[VEC_W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign acc_new_o       = fresh_d;
    assign eoi_ntf_valid_o = s_q.ntf_valid;
    assign eoi_ntf_vec_o   = s_q.ntf_vec;
    assign tpr_q           = s_q.tpr;
    assign svc_q           = s_q.svc;
endmodule

// File: rtl/irq_prio_checker.sv
`timescale 1ns/1ps
module irq_prio_checker #(
    parameter int unsigned NUM_VEC = 256
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       en,
    input logic                       ack_valid,
    input logic [$clog2(NUM_VEC)-1:0] ack_vec,
    input logic                       eoi,
    input logic                       pend_valid,
    input logic [$clog2(NUM_VEC)-1:0] pend_vec,
    input logic [$clog2(NUM_VEC)-1:0] ppr,
    input logic                       ntf_valid,
    input logic [$clog2(NUM_VEC)-1:0] ntf_vec,
    input logic [$clog2(NUM_VEC)-1:0] tpr_q,
    input logic [NUM_VEC-1:0]         svc_q,
    input logic                       svc_found,
    input logic [$clog2(NUM_VEC)-1:0] svc_top
);
    localparam int unsigned VEC_W = $clog2(NUM_VEC);

    p_ppr_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ppr >= tpr_q);

    p_pend_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> en);

    p_pend_above_svc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && svc_found) |-> (pend_vec[VEC_W-1 -: 4] > svc_top[VEC_W-1 -: 4]));

    p_ack_sets_svc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> svc_q[$past(ack_vec)]);

    p_eoi_clears_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && svc_found && !(ack_valid && ack_vec == svc_top)) |=> !svc_q[$past(svc_top)]);

    p_ntf_from_eoi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_valid |-> ($past(eoi) && $past(svc_found) && ntf_vec == $past(svc_top)));
endmodule

bind irq_prio_tracker irq_prio_checker #(.NUM_VEC(NUM_VEC)) u_chk (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .en        (en_i),
    .ack_valid (ack_valid_i),
    .ack_vec   (ack_vec_i),
    .eoi       (eoi_i),
    .pend_valid(pend_valid_o),
    .pend_vec  (pend_vec_o),
    .ppr       (ppr_o),
    .ntf_valid (eoi_ntf_valid_o),
    .ntf_vec   (eoi_ntf_vec_o),
    .tpr_q     (tpr_q),
    .svc_q     (svc_q),
    .svc_found (svc_found),
    .svc_top   (svc_top)
);

// File: tb/sim_irq_prio_tracker.sv
`timescale 1ns/1ps
module sim_irq_prio_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1;
    logic        acc_valid = 1'b0;
    logic [7:0]  acc_vec = '0;
    logic        acc_level = 1'b0;
    logic        acc_new;
    logic        ack_valid = 1'b0;
    logic [7:0]  ack_vec = '0;
    logic        eoi = 1'b0;
    logic        tpr_we = 1'b0;
    logic [31:0] tpr_wdata = '0;
    logic        pend_valid;
    logic [7:0]  pend_vec;
    logic [7:0]  ppr;
    logic        ntf_valid;
    logic [7:0]  ntf_vec;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_prio_tracker u0 (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en),
        .acc_valid_i(acc_valid), .acc_vec_i(acc_vec), .acc_level_i(acc_level),
        .acc_new_o(acc_new),
        .ack_valid_i(ack_valid), .ack_vec_i(ack_vec),
        .eoi_i(eoi), .tpr_we_i(tpr_we), .tpr_wdata_i(tpr_wdata),
        .pend_valid_o(pend_valid), .pend_vec_o(pend_vec), .ppr_o(ppr),
        .eoi_ntf_valid_o(ntf_valid), .eoi_ntf_vec_o(ntf_vec)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic pend_is(input string req, input logic v, input logic [7:0] vec);
        check({req, " pend_valid"}, 32'(pend_valid), 32'(v));
        if (v) check({req, " pend_vec"}, 32'(pend_vec), 32'(vec));
    endtask

    task automatic edge_wait();
        @(posedge clk);
        #1;
    endtask

    task automatic do_accept(input string req, input logic [7:0] v, input logic lvl, input logic exp_new);
        acc_valid = 1'b1; acc_vec = v; acc_level = lvl;
        #1 check({req, " acc_new"}, 32'(acc_new), 32'(exp_new));
        edge_wait();
        acc_valid = 1'b0; acc_level = 1'b0;
    endtask

    task automatic do_ack(input logic [7:0] v);
        ack_valid = 1'b1; ack_vec = v;
        edge_wait();
        ack_valid = 1'b0;
    endtask

    task automatic do_eoi();
        eoi = 1'b1;
        edge_wait();
        eoi = 1'b0;
    endtask

    task automatic do_tpr(input logic [31:0] d);
        tpr_we = 1'b1; tpr_wdata = d;
        edge_wait();
        tpr_we = 1'b0;
    endtask

    task automatic t_reset();
        check("R8 reset pend_valid", 32'(pend_valid), 0);
        check("R8 reset ppr", 32'(ppr), 0);
        check("R8 reset ntf", 32'(ntf_valid), 0);
    endtask

    task automatic t_tpr();
        do_tpr(32'h0000_01A5);
        check("R8 tpr low byte / R3 ppr", 32'(ppr), 32'hA5);
        do_tpr(32'h0);
        check("R3 ppr zero", 32'(ppr), 0);
    endtask

    task automatic t_accept();
        do_accept("R1 first", 8'h41, 1'b0, 1'b1);
        pend_is("R1 single", 1'b1, 8'h41);
        do_accept("R1 repeat", 8'h41, 1'b0, 1'b0);
        do_accept("R1 lower", 8'h30, 1'b0, 1'b1);
        pend_is("R1 highest kept", 1'b1, 8'h41);
        do_accept("R1 top word", 8'hE0, 1'b0, 1'b1);
        pend_is("R1 cross word", 1'b1, 8'hE0);
    endtask

    task automatic t_disable();
        en = 1'b0;
        #1 pend_is("R4 disabled", 1'b0, 8'h0);
        do_accept("R9 disabled accept", 8'hF5, 1'b0, 1'b0);
        en = 1'b1;
        #1 pend_is("R9 state untouched", 1'b1, 8'hE0);
    endtask

    task automatic t_ack();
        do_ack(8'hE0);
        pend_is("R4 R5 masked by service", 1'b0, 8'h0);
        check("R3 ppr from service", 32'(ppr), 32'hE0);
        do_tpr(32'hF3);
        check("R3 ppr from task", 32'(ppr), 32'hF3);
        do_tpr(32'h20);
        check("R3 ppr class", 32'(ppr), 32'hE0);
        do_tpr(32'h0);
    endtask

    task automatic t_eoi_edge();
        do_eoi();
        check("R7 edge no ntf", 32'(ntf_valid), 0);
        pend_is("R5 R6 request cleared by ack", 1'b1, 8'h41);
        check("R6 ppr after eoi", 32'(ppr), 0);
    endtask

    task automatic t_level();
        do_accept("R2 level", 8'h52, 1'b1, 1'b1);
        pend_is("R2 pend", 1'b1, 8'h52);
        do_ack(8'h52);
        do_eoi();
        check("R7 ntf valid", 32'(ntf_valid), 1);
        check("R7 ntf vec", 32'(ntf_vec), 32'h52);
        edge_wait();
        check("R7 ntf one cycle", 32'(ntf_valid), 0);
        do_accept("R2 edge again", 8'h52, 1'b0, 1'b1);
        do_ack(8'h52);
        do_eoi();
        check("R2 R7 trigger bit cleared", 32'(ntf_valid), 0);
        pend_is("R6 back to lower", 1'b1, 8'h41);
    endtask

    task automatic t_empty_eoi();
        do_eoi();
        check("R6 empty eoi ntf", 32'(ntf_valid), 0);
        pend_is("R6 empty eoi pend", 1'b1, 8'h41);
        check("R6 empty eoi ppr", 32'(ppr), 0);
    endtask

    task automatic t_equal_class();
        do_ack(8'h41);
        pend_is("R4 lower class", 1'b0, 8'h0);
        do_accept("R4 equal", 8'h4F, 1'b0, 1'b1);
        pend_is("R4 equal class blocked", 1'b0, 8'h0);
        do_accept("R4 higher", 8'h50, 1'b0, 1'b1);
        pend_is("R4 higher class", 1'b1, 8'h50);
        do_ack(8'h50);
        check("R3 ppr nested", 32'(ppr), 32'h50);
        do_eoi();
        check("R6 highest ended first", 32'(ppr), 32'h40);
        pend_is("R6 still blocked", 1'b0, 8'h0);
        do_eoi();
        pend_is("R6 second eoi", 1'b1, 8'h4F);
    endtask

    task automatic t_same_cycle();
        acc_valid = 1'b1; acc_vec = 8'h60; ack_valid = 1'b1; ack_vec = 8'h60;
        edge_wait();
        acc_valid = 1'b0; ack_valid = 1'b0;
        check("R10 in service", 32'(ppr), 32'h60);
        pend_is("R10 blocked", 1'b0, 8'h0);
        do_eoi();
        pend_is("R10 request kept", 1'b1, 8'h60);
    endtask

    task automatic t_reset_mid();
        rst_n = 1'b0;
        #1;
        check("R8 mid reset pend", 32'(pend_valid), 0);
        check("R8 mid reset ppr", 32'(ppr), 0);
        edge_wait();
        rst_n = 1'b1;
        do_accept("R8 request cleared", 8'h60, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_tpr();
        t_accept();
        t_disable();
        t_ack();
        t_eoi_edge();
        t_level();
        t_empty_eoi();
        t_equal_class();
        t_same_cycle();
        t_reset_mid();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule